// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block performs the rotate-then-mask step used by integer rotate instructions. A 64-bit source is rotated left by a 6-bit amount, and the rotated value is ANDed with a mask. The mask is described by a begin index and an end index, and it may wrap around the word. Bit indices are big-endian: index 0 is the most significant bit and index 63 is the least significant.

A mode input selects doubleword or word operation. In word mode, the low 32 bits of the source are copied into both halves of a 64-bit operand, and that operand is rotated. The rotate amount is taken modulo 32. The mask indices keep only their low five bits, and 32 is added to each, so the mask covers the low word. The unit is purely combinational: a change on any input reaches the result with no clock.

Top module: `rotmask_unit`

## Requirements
- R1: With `wordMode`=0, the operand is the full 64-bit source. It is rotated left by `rotAmount` (0..63). The bits that leave at the most significant end come back in at the least significant end.
- R2: When begin <= end, the mask has ones at big-endian indices begin through end, inclusive. Index i corresponds to bit 63-i of the result, and every other mask bit is zero.
- R3: When begin > end, the mask wraps around. It has ones from index begin through index 63, and from index 0 through index end. Begin = end+1 therefore gives an all-ones mask.
- R4: With `wordMode`=1, the operand is {src[31:0], src[31:0]}. `srcData[63:32]` has no effect on the result.
- R5: With `wordMode`=1, the rotate amount is `rotAmount` modulo 32, so `rotAmount[5]` has no effect.
- R6: With `wordMode`=1, the effective mask indices are `maskBegin[4:0]`+32 and `maskEnd[4:0]`+32. Bit 5 of each index input has no effect.
- R7: `resultData` equals the rotated operand ANDed with the mask. It holds no state and follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcData | input | 64 | Source value to rotate |
| rotAmount | input | 6 | Left-rotate amount |
| maskBegin | input | 6 | First mask index (0 = MSB) |
| maskEnd | input | 6 | Last mask index (inclusive) |
| wordMode | input | 1 | 0 = doubleword, 1 = word |
| resultData | output | 64 | Rotated and masked value |

## Verification
The rotate is tried with a distinctive doubleword pattern at amounts 0, 10, 35 and 63. These amounts separate a correct wrap of the high bits from a plain shift, and they catch an off-by-one in the amount. The mask is tried with an all-ones source under normal, single-bit, wrapping and begin = end+1 index pairs. These cases separate inclusive bounds from exclusive bounds, and a wrapping mask from an empty mask. The word-mode cases put garbage in the upper source word and set bit 5 of the amount and index inputs. A result that matches the plain word rotate then shows that the low word was replicated and that the extra bits were ignored.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned HALF_W = DATA_W / 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             wordSel;
    logic [IDX_W-1:0] rotAmt;
    logic [IDX_W-1:0] maskFirst;
    logic [IDX_W-1:0] maskLast;
  } rmStrobe_t;
endpackage

// File: rtl/rotmask_ctrl.sv
module rotmask_ctrl
  import rotmask_pkg::*;
(
  input  logic             modeIn,
  input  logic [IDX_W-1:0] rotIn,
  input  logic [IDX_W-1:0] firstIn,
  input  logic [IDX_W-1:0] lastIn,
  output rmStrobe_t        strb
);
  always_comb begin
    strb.wordSel = modeIn;
    if (modeIn) begin
      strb.rotAmt    = {1'b0, rotIn[IDX_W-2:0]};
      strb.maskFirst = {1'b1, firstIn[IDX_W-2:0]};
      strb.maskLast  = {1'b1, lastIn[IDX_W-2:0]};
    end else begin
      strb.rotAmt    = rotIn;
      strb.maskFirst = firstIn;
      strb.maskLast  = lastIn;
    end
  end

  always_comb begin
    if (modeIn) begin
      assert_word_amount_R5: assert (strb.rotAmt < IDX_W'(HALF_W))
        else $error("word-mode rotate amount out of range");
    end
  end
endmodule

// File: rtl/rotmask_datapath.sv
module rotmask_datapath
  import rotmask_pkg::*;
(
  input  logic [DATA_W-1:0] srcIn,
  input  rmStrobe_t         strb,
  output logic [DATA_W-1:0] resultOut
);
  logic [DATA_W-1:0]   operand;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   maskVec;
  logic                wrapMask;

  assign operand  = strb.wordSel ? {srcIn[HALF_W-1:0], srcIn[HALF_W-1:0]} : srcIn;
  assign shifted  = {operand, operand} << strb.rotAmt;
  assign rotated  = shifted[2*DATA_W-1:DATA_W];
  assign wrapMask = strb.maskFirst > strb.maskLast;

  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    localparam logic [IDX_W-1:0] POS = IDX_W'(k);
    logic geFirst, leLast;
    assign geFirst = POS >= strb.maskFirst;
    assign leLast  = POS <= strb.maskLast;
    assign maskVec[DATA_W-1-k] = wrapMask ? (geFirst | leLast) : (geFirst & leLast);
  end

  assign resultOut = rotated & maskVec;

  always_comb begin
    assert_begin_bit_set_R2: assert (maskVec[DATA_W-1-int'(strb.maskFirst)])
      else $error("mask begin bit clear");
    if (!wrapMask) begin
      assert_span_count_R2: assert ($countones(maskVec) ==
          int'(strb.maskLast) - int'(strb.maskFirst) + 1)
        else $error("mask span count wrong");
    end else begin
      assert_wrap_count_R3: assert ($countones(maskVec) ==
          DATA_W - (int'(strb.maskFirst) - int'(strb.maskLast) - 1))
        else $error("wrap mask count wrong");
    end
    if (strb.wordSel) begin
      assert_halves_equal_R4: assert (rotated[DATA_W-1:HALF_W] == rotated[HALF_W-1:0])
        else $error("word rotate halves differ");
    end
    assert_outside_mask_zero_R7: assert ((resultOut & ~maskVec) == '0)
      else $error("result bit outside mask");
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
(
  input  logic [DATA_W-1:0] srcData,
  input  logic [IDX_W-1:0]  rotAmount,
  input  logic [IDX_W-1:0]  maskBegin,
  input  logic [IDX_W-1:0]  maskEnd,
  input  logic              wordMode,
  output logic [DATA_W-1:0] resultData
);
  rmStrobe_t strb;

  rotmask_ctrl ctrl_i (
    .modeIn (wordMode),
    .rotIn  (rotAmount),
    .firstIn(maskBegin),
    .lastIn (maskEnd),
    .strb   (strb)
  );

  rotmask_datapath dp_i (
    .srcIn    (srcData),
    .strb     (strb),
    .resultOut(resultData)
  );
endmodule

// File: tb/rotmask_unit_tb_top.sv
module rotmask_unit_tb_top;
  logic        clk = 1'b0;
  logic [63:0] srcData;
  logic [5:0]  rotAmount, maskBegin, maskEnd;
  logic        wordMode;
  logic [63:0] resultData;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rotmask_unit dut_i (
    .srcData(srcData), .rotAmount(rotAmount), .maskBegin(maskBegin),
    .maskEnd(maskEnd), .wordMode(wordMode), .resultData(resultData)
  );

  function automatic logic [63:0] refRot(input logic [63:0] v, input int n);
    int m = n % 64;
    if (m == 0) return v;
    return (v << m) | (v >> (64 - m));
  endfunction

  function automatic logic [63:0] refMask(input int b, input int e);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++)
      if ((b <= e) ? (i >= b && i <= e) : (i >= b || i <= e)) m[63-i] = 1'b1;
    return m;
  endfunction

  task automatic apply(input logic [63:0] s, input int r, input int b,
                       input int e, input logic w);
    srcData = s; rotAmount = 6'(r); maskBegin = 6'(b);
    maskEnd = 6'(e); wordMode = w;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (resultData !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, resultData, exp);
    end
  endtask

  task automatic test_reset_state;
    apply('0, 0, 0, 63, 1'b0);
    check("R7 zero source", 64'h0);
  endtask

  task automatic test_dword_rotate;  // R1
    apply(64'hdeadbeef12345678, 0, 0, 63, 1'b0);
    check("R1 rot0", 64'hdeadbeef12345678);
    apply(64'hdeadbeef12345678, 10, 0, 63, 1'b0);
    check("R1 rot10", 64'hb6fbbc48d159e37a);
    apply(64'hdeadbeef12345678, 35, 0, 63, 1'b0);
    check("R1 rot35", 64'h91a2b3c6f56df778);
    apply(64'hdeadbeef12345678, 63, 0, 63, 1'b0);
    check("R1 rot63", refRot(64'hdeadbeef12345678, 63));
  endtask

  task automatic test_plain_mask;  // R2
    apply('1, 0, 37, 63, 1'b0);
    check("R2 37..63", 64'h0000000007ffffff);
    apply('1, 0, 0, 37, 1'b0);
    check("R2 0..37", 64'hfffffffffc000000);
    apply('1, 0, 32, 32, 1'b0);
    check("R2 single 32", 64'h0000000080000000);
    apply('1, 0, 63, 63, 1'b0);
    check("R2 single 63", 64'h1);
  endtask

  task automatic test_wrap_mask;  // R3
    apply('1, 0, 47, 37, 1'b0);
    check("R3 wrap 47/37", 64'hfffffffffc01ffff);
    apply('1, 0, 38, 37, 1'b0);
    check("R3 begin=end+1", '1);
    apply('1, 0, 63, 0, 1'b0);
    check("R3 ends only", 64'h8000000000000001);
  endtask

  task automatic test_word_mode;  // R4 R5 R6
    apply(64'h00000000deadbeef, 10, 0, 31, 1'b1);
    check("R4 word rot10", 64'h00000000b6fbbf7a);
    apply(64'h123456789abcdef0 & 64'hffffffff00000000 | 64'hdeadbeef, 10, 0, 31, 1'b1);
    check("R4 upper ignored", 64'h00000000b6fbbf7a);
    apply(64'h00000000deadbeef, 42, 0, 31, 1'b1);
    check("R5 amt bit5 ignored", 64'h00000000b6fbbf7a);
    apply(64'hffffffffffffffff, 0, 5, 15, 1'b1);
    check("R6 mask 5..15", 64'h0000000007ff0000);
    apply(64'hffffffffffffffff, 0, 37, 47, 1'b1);
    check("R6 idx bit5 ignored", 64'h0000000007ff0000);
    apply(64'hffffffffffffffff, 0, 15, 5, 1'b1);
    check("R6 word wrap", 64'hfffffffffc01ffff);
    apply(64'hcafef00d5a5a0f0f, 7, 3, 28, 1'b1);
    check("R4 mixed", refRot({32'h5a5a0f0f, 32'h5a5a0f0f}, 7) & refMask(35, 60));
  endtask

  task automatic test_combined;  // R7
    apply(64'h0123456789abcdef, 20, 50, 12, 1'b0);
    check("R7 rot and wrap", refRot(64'h0123456789abcdef, 20) & refMask(50, 12));
    rotAmount = 6'd44; #1;
    check("R7 comb update", refRot(64'h0123456789abcdef, 44) & refMask(50, 12));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_reset_state();
    test_dword_rotate();
    test_plain_mask();
    test_wrap_mask();
    test_word_mode();
    test_combined();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule